// File: doc/BRIEF.md
# Interrupt Stacking and Return Sequencer

This block steps an 8-bit processor with a 16-bit address bus through an interrupt entry and through a return from interrupt. It issues one memory access per clock cycle. On entry it saves five context bytes on a stack that grows downward, sets the interrupt mask bit in the condition code register, reads a two-byte vector from the address an external arbiter supplies, and fetches the first opcode of the handler. On a return request it reads the five bytes back in the opposite order, reloads the accumulator, the index register, the condition codes and the program counter, and fetches the opcode at the restored address.

The processor's register file presents its live values on the inputs. The sequencer captures them in the cycle it accepts an entry request, so later changes on those inputs have no effect on the frame being written. Memory returns read data on `mem_rdata` in the same cycle the address is presented, and the sequencer samples it at the closing clock edge. All bus and load outputs are registered. The stack pointer lives inside the block and is visible on `sp_out`.

Top module: `irq_stack_seq`

## Requirements
- R1: While reset is high and after it is released, `busy`, `mem_valid`, `pc_load`, `ccr_load` and `ax_load` are 0, and `sp_out` equals the `SP_RESET` parameter (default 0x00FF).
- R2: An entry request accepted while idle produces five back-to-back write cycles (`mem_read`=0). They go to addresses SP, SP-1, SP-2, SP-3 and SP-4, where SP is the pointer at acceptance. In that order they carry bits [7:0] of `pc_in`-1, bits [15:8] of `pc_in`-1, `x_in`, `a_in` and `ccr_in`, all sampled at the accepting edge.
- R3: After the writes, the entry reads `vec_addr` (vector high byte) and then `vec_addr`+1 (vector low byte). The next cycle is a read at {high,low}, and in that cycle `pc_load`=1 and `pc_new` = {high,low}.
- R4: In the cycle of the vector high-byte read, `ccr_load` pulses with `ccr_new` equal to the stacked condition codes with bit `I_BIT` (default 3) set and every other bit unchanged.
- R5: The stack pointer moves after each write (post-decrement) and before each stack read (pre-increment). During a write cycle `sp_out` is one below `mem_addr`. After an entry it is 5 below its start, and after a return it is 5 above its start.
- R6: A return request accepted while idle produces five reads at SP+1 through SP+5, which return the condition codes, A, X, the PC high byte and the PC low byte, in that order. It then reads at the restored PC, and in that cycle `pc_load`, `ax_load` and `ccr_load` are all 1 with the restored values on `pc_new`, `a_new`, `x_new` and `ccr_new`.
- R7: The condition codes loaded on return are exactly the stacked byte, so an interrupt mask bit that was clear before entry is clear again after the return.
- R8: `mem_read` is 1 for vector, stack and opcode reads and 0 for stack writes. `mem_valid` is 1 in every busy cycle and 0 in every idle cycle, with no loads while idle.
- R9: `busy` is high from the first bus cycle through the opcode fetch (8 cycles for an entry, 6 for a return). Entry or return requests that arrive while busy are ignored: the running sequence is not restarted or changed, and no new sequence follows it.
- R10: When entry and return requests arrive together while idle, the entry sequence runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_req | input | 1 | Start an interrupt entry sequence |
| rti_req | input | 1 | Start a return-from-interrupt sequence |
| vec_addr | input | 16 | Address of the vector high byte, from the arbiter |
| pc_in | input | 16 | Current program counter (PC-1 is stacked) |
| a_in | input | 8 | Accumulator value |
| x_in | input | 8 | Index register value |
| ccr_in | input | 8 | Condition code register value |
| mem_rdata | input | 8 | Read data for the current bus cycle |
| mem_addr | output | 16 | Bus address |
| mem_wdata | output | 8 | Write data (0 on reads) |
| mem_read | output | 1 | 1 = read, 0 = write |
| mem_valid | output | 1 | A bus access happens this cycle |
| busy | output | 1 | A sequence is in progress |
| sp_out | output | 16 | Stack pointer |
| pc_new | output | 16 | Program counter to load |
| pc_load | output | 1 | Load `pc_new` |
| a_new | output | 8 | Restored accumulator |
| x_new | output | 8 | Restored index register |
| ax_load | output | 1 | Load `a_new` and `x_new` |
| ccr_new | output | 8 | Condition codes to load |
| ccr_load | output | 1 | Load `ccr_new` |

## Verification
A return from a preloaded frame checks the pull order and the pre-increment on its own, before any entry has run. It also shows that a clear mask bit comes back clear. An entry with requests injected mid-sequence and the register inputs changed at the same time shows whether the block uses its own snapshot and ignores requests while busy. A second, nested entry made with both requests raised shows the priority of entry over return and a frame placed below the first. Two returns then unwind the frames in LIFO order. They tell a correct mirror-order restore from a same-order restore, and a restored mask bit from a bit left forced to 1.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int FRAME_BYTES = 5;
  localparam int ENTRY_LAST  = FRAME_BYTES + 2;
  localparam int RETURN_LAST = FRAME_BYTES;
  localparam int STEP_W      = $clog2(ENTRY_LAST + 1);

  typedef enum logic [1:0] {
    MODE_IDLE   = 2'd0,
    MODE_ENTRY  = 2'd1,
    MODE_RETURN = 2'd2
  } mode_t;
endpackage

// File: rtl/irq_seq_ctrl.sv
module irq_seq_ctrl
  import irq_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              entry_req,
  input  logic              rti_req,
  output mode_t             mode_q,
  output logic [STEP_W-1:0] step_q,
  output mode_t             nxt_mode,
  output logic [STEP_W-1:0] nxt_step,
  output logic              busy
);
  logic at_last;

  always_comb begin
    at_last = (mode_q == MODE_ENTRY  && step_q == STEP_W'(ENTRY_LAST)) ||
              (mode_q == MODE_RETURN && step_q == STEP_W'(RETURN_LAST));
    nxt_mode = mode_q;
    nxt_step = step_q;
    if (mode_q == MODE_IDLE) begin
      nxt_step = '0;
      if (entry_req)    nxt_mode = MODE_ENTRY;
      else if (rti_req) nxt_mode = MODE_RETURN;
    end else if (at_last) begin
      nxt_mode = MODE_IDLE;
      nxt_step = '0;
    end else begin
      nxt_step = step_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_IDLE;
      step_q <= '0;
    end else begin
      mode_q <= nxt_mode;
      step_q <= nxt_step;
    end
  end

  assign busy = (mode_q != MODE_IDLE);
endmodule

// File: rtl/irq_sp_unit.sv
module irq_sp_unit #(
  parameter int          AW       = 16,
  parameter int unsigned SP_RESET = 'h00FF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          dec,
  input  logic          inc,
  output logic [AW-1:0] sp_q
);
  always_ff @(posedge clk) begin
    if (rst)      sp_q <= AW'(SP_RESET);
    else if (dec) sp_q <= sp_q - 1'b1;
    else if (inc) sp_q <= sp_q + 1'b1;
  end
endmodule

// File: rtl/irq_frame_capture.sv
module irq_frame_capture
  import irq_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              grab,
  input  logic [AW-1:0]                     pc_in,
  input  logic [DW-1:0]                     a_in,
  input  logic [DW-1:0]                     x_in,
  input  logic [DW-1:0]                     ccr_in,
  input  logic                              pull_en,
  input  logic [STEP_W-1:0]                 pull_idx,
  input  logic                              vec_en,
  input  logic [DW-1:0]                     din,
  output logic [FRAME_BYTES-1:0][DW-1:0]    live_bytes,
  output logic [FRAME_BYTES-1:0][DW-1:0]    snap_q,
  output logic [FRAME_BYTES-2:0][DW-1:0]    pull_q,
  output logic [DW-1:0]                     vec_hi_q
);
  logic [AW-1:0] ret_pc;

  // push order: PC low, PC high, X, A, CCR
  always_comb begin
    ret_pc        = pc_in - 1'b1;
    live_bytes[0] = ret_pc[DW-1:0];
    live_bytes[1] = ret_pc[2*DW-1:DW];
    live_bytes[2] = x_in;
    live_bytes[3] = a_in;
    live_bytes[4] = ccr_in;
  end

  always_ff @(posedge clk) begin
    if (rst)       snap_q <= '0;
    else if (grab) snap_q <= live_bytes;
  end

  // pull slots: 0 CCR, 1 A, 2 X, 3 PC high (PC low is used straight from din)
  for (genvar i = 0; i < FRAME_BYTES - 1; i++) begin : g_pull
    always_ff @(posedge clk) begin
      if (rst) pull_q[i] <= '0;
      else if (pull_en && pull_idx == STEP_W'(i)) pull_q[i] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         vec_hi_q <= '0;
    else if (vec_en) vec_hi_q <= din;
  end
endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import irq_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int I_BIT = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  mode_t                          nxt_mode,
  input  logic [STEP_W-1:0]              nxt_step,
  input  logic [AW-1:0]                  sp,
  input  logic [AW-1:0]                  vec_addr,
  input  logic [DW-1:0]                  din,
  input  logic [FRAME_BYTES-1:0][DW-1:0] live_bytes,
  input  logic [FRAME_BYTES-1:0][DW-1:0] snap_q,
  input  logic [FRAME_BYTES-2:0][DW-1:0] pull_q,
  input  logic [DW-1:0]                  vec_hi_q,
  output logic [AW-1:0]                  mem_addr,
  output logic [DW-1:0]                  mem_wdata,
  output logic                           mem_read,
  output logic                           mem_valid,
  output logic [AW-1:0]                  pc_new,
  output logic                           pc_load,
  output logic [DW-1:0]                  a_new,
  output logic [DW-1:0]                  x_new,
  output logic                           ax_load,
  output logic [DW-1:0]                  ccr_new,
  output logic                           ccr_load
);
  logic [AW-1:0] d_addr, d_pc;
  logic [DW-1:0] d_wdata, d_a, d_x, d_ccr, push_byte;
  logic          d_read, d_valid, d_pcl, d_axl, d_ccrl;
  logic          in_frame;

  always_comb begin
    in_frame  = nxt_step < STEP_W'(FRAME_BYTES);
    push_byte = live_bytes[0];
    for (int i = 1; i < FRAME_BYTES; i++)
      if (nxt_step == STEP_W'(i)) push_byte = snap_q[i];

    d_addr  = '0;
    d_wdata = '0;
    d_read  = 1'b0;
    d_valid = 1'b0;
    d_pc    = '0;
    d_pcl   = 1'b0;
    d_a     = '0;
    d_x     = '0;
    d_axl   = 1'b0;
    d_ccr   = '0;
    d_ccrl  = 1'b0;

    unique case (nxt_mode)
      MODE_ENTRY: begin
        d_valid = 1'b1;
        if (in_frame) begin
          d_addr  = sp;
          d_wdata = push_byte;
        end else if (nxt_step == STEP_W'(FRAME_BYTES)) begin
          d_read = 1'b1;
          d_addr = vec_addr;
          d_ccr  = snap_q[FRAME_BYTES-1] | DW'(1 << I_BIT);
          d_ccrl = 1'b1;
        end else if (nxt_step == STEP_W'(FRAME_BYTES + 1)) begin
          d_read = 1'b1;
          d_addr = vec_addr + 1'b1;
        end else begin
          d_read = 1'b1;
          d_addr = {vec_hi_q, din};
          d_pc   = {vec_hi_q, din};
          d_pcl  = 1'b1;
        end
      end
      MODE_RETURN: begin
        d_valid = 1'b1;
        d_read  = 1'b1;
        if (in_frame) begin
          d_addr = sp + 1'b1;
        end else begin
          d_addr = {pull_q[3], din};
          d_pc   = {pull_q[3], din};
          d_pcl  = 1'b1;
          d_ccr  = pull_q[0];
          d_a    = pull_q[1];
          d_x    = pull_q[2];
          d_ccrl = 1'b1;
          d_axl  = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr  <= '0;
      mem_wdata <= '0;
      mem_read  <= 1'b0;
      mem_valid <= 1'b0;
      pc_new    <= '0;
      pc_load   <= 1'b0;
      a_new     <= '0;
      x_new     <= '0;
      ax_load   <= 1'b0;
      ccr_new   <= '0;
      ccr_load  <= 1'b0;
    end else begin
      mem_addr  <= d_addr;
      mem_wdata <= d_wdata;
      mem_read  <= d_read;
      mem_valid <= d_valid;
      pc_new    <= d_pc;
      pc_load   <= d_pcl;
      a_new     <= d_a;
      x_new     <= d_x;
      ax_load   <= d_axl;
      ccr_new   <= d_ccr;
      ccr_load  <= d_ccrl;
    end
  end
endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq
  import irq_seq_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int          DW       = 8,
  parameter int unsigned SP_RESET = 'h00FF,
  parameter int          I_BIT    = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          entry_req,
  input  logic          rti_req,
  input  logic [AW-1:0] vec_addr,
  input  logic [AW-1:0] pc_in,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] x_in,
  input  logic [DW-1:0] ccr_in,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_read,
  output logic          mem_valid,
  output logic          busy,
  output logic [AW-1:0] sp_out,
  output logic [AW-1:0] pc_new,
  output logic          pc_load,
  output logic [DW-1:0] a_new,
  output logic [DW-1:0] x_new,
  output logic          ax_load,
  output logic [DW-1:0] ccr_new,
  output logic          ccr_load
);
  mode_t                          mode_q, nxt_mode;
  logic [STEP_W-1:0]              step_q, nxt_step;
  logic                           sp_dec, sp_inc, grab, pull_en, vec_en;
  logic [FRAME_BYTES-1:0][DW-1:0] live_bytes, snap_q;
  logic [FRAME_BYTES-2:0][DW-1:0] pull_q;
  logic [DW-1:0]                  vec_hi_q;

  irq_seq_ctrl u_ctrl (
    .clk(clk), .rst(rst), .entry_req(entry_req), .rti_req(rti_req),
    .mode_q(mode_q), .step_q(step_q), .nxt_mode(nxt_mode),
    .nxt_step(nxt_step), .busy(busy)
  );

  always_comb begin
    sp_dec  = (nxt_mode == MODE_ENTRY)  && (nxt_step < STEP_W'(FRAME_BYTES));
    sp_inc  = (nxt_mode == MODE_RETURN) && (nxt_step < STEP_W'(FRAME_BYTES));
    grab    = (mode_q == MODE_IDLE) && (nxt_mode == MODE_ENTRY);
    pull_en = (mode_q == MODE_RETURN) && (step_q < STEP_W'(FRAME_BYTES - 1));
    vec_en  = (mode_q == MODE_ENTRY) && (step_q == STEP_W'(FRAME_BYTES));
  end

  irq_sp_unit #(.AW(AW), .SP_RESET(SP_RESET)) u_sp (
    .clk(clk), .rst(rst), .dec(sp_dec), .inc(sp_inc), .sp_q(sp_out)
  );

  irq_frame_capture #(.AW(AW), .DW(DW)) u_frame (
    .clk(clk), .rst(rst), .grab(grab), .pc_in(pc_in), .a_in(a_in),
    .x_in(x_in), .ccr_in(ccr_in), .pull_en(pull_en), .pull_idx(step_q),
    .vec_en(vec_en), .din(mem_rdata), .live_bytes(live_bytes),
    .snap_q(snap_q), .pull_q(pull_q), .vec_hi_q(vec_hi_q)
  );

  irq_bus_regs #(.AW(AW), .DW(DW), .I_BIT(I_BIT)) u_bus (
    .clk(clk), .rst(rst), .nxt_mode(nxt_mode), .nxt_step(nxt_step),
    .sp(sp_out), .vec_addr(vec_addr), .din(mem_rdata),
    .live_bytes(live_bytes), .snap_q(snap_q), .pull_q(pull_q),
    .vec_hi_q(vec_hi_q), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_read(mem_read), .mem_valid(mem_valid), .pc_new(pc_new),
    .pc_load(pc_load), .a_new(a_new), .x_new(x_new), .ax_load(ax_load),
    .ccr_new(ccr_new), .ccr_load(ccr_load)
  );
endmodule

// File: rtl/irq_seq_checker.sv
module irq_seq_checker #(
  parameter int AW    = 16,
  parameter int DW    = 8,
  parameter int I_BIT = 3
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] mem_addr,
  input logic          mem_read,
  input logic          mem_valid,
  input logic          busy,
  input logic [AW-1:0] sp_out,
  input logic          pc_load,
  input logic          ax_load,
  input logic [DW-1:0] ccr_new,
  input logic          ccr_load
);
  assert_access_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> mem_valid);

  assert_quiet_when_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_valid && !pc_load && !ccr_load && !ax_load));

  assert_push_post_dec_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_read) |-> (sp_out == AW'(mem_addr - 1'b1)));

  assert_push_descends_R2: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_read && $past(mem_valid && !mem_read))
      |-> (mem_addr == AW'($past(mem_addr) - 1'b1)));

  assert_mask_set_on_entry_R4: assert property (@(posedge clk) disable iff (rst)
    (ccr_load && !ax_load) |-> ccr_new[I_BIT]);

  assert_return_loads_together_R6: assert property (@(posedge clk) disable iff (rst)
    ax_load |-> (ccr_load && pc_load && mem_read));

  assert_done_after_pc_load_R9: assert property (@(posedge clk) disable iff (rst)
    pc_load |=> !busy);
endmodule

bind irq_stack_seq irq_seq_checker #(.AW(AW), .DW(DW), .I_BIT(I_BIT)) u_irq_seq_checker (
  .clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_read(mem_read),
  .mem_valid(mem_valid), .busy(busy), .sp_out(sp_out), .pc_load(pc_load),
  .ax_load(ax_load), .ccr_new(ccr_new), .ccr_load(ccr_load)
);

// File: tb/irq_stack_seq_bench.sv
`timescale 1ns/1ps
module irq_stack_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        entry_req = 1'b0, rti_req = 1'b0;
  logic [15:0] vec_addr = '0, pc_in = '0;
  logic [7:0]  a_in = '0, x_in = '0, ccr_in = '0;
  logic [7:0]  mem_rdata;
  logic [15:0] mem_addr, sp_out, pc_new;
  logic [7:0]  mem_wdata, a_new, x_new, ccr_new;
  logic        mem_read, mem_valid, busy, pc_load, ax_load, ccr_load;

  always #4 clk = ~clk;

  irq_stack_seq u_irq_stack_seq (
    .clk(clk), .rst(rst), .entry_req(entry_req), .rti_req(rti_req),
    .vec_addr(vec_addr), .pc_in(pc_in), .a_in(a_in), .x_in(x_in),
    .ccr_in(ccr_in), .mem_rdata(mem_rdata), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_read(mem_read), .mem_valid(mem_valid),
    .busy(busy), .sp_out(sp_out), .pc_new(pc_new), .pc_load(pc_load),
    .a_new(a_new), .x_new(x_new), .ax_load(ax_load), .ccr_new(ccr_new),
    .ccr_load(ccr_load)
  );

  int checks = 0, failures = 0;

  // memory model: asynchronous read, write recorded mid-cycle
  logic [7:0] mem [logic [15:0]];
  always @* begin
    if (mem_valid && mem_read && mem.exists(mem_addr)) mem_rdata = mem[mem_addr];
    else mem_rdata = 8'h00;
  end

  typedef struct {
    logic [15:0] addr;
    logic        rd;
    logic [7:0]  wd;
    logic [15:0] sp;
    logic        pcl;
    logic [15:0] pc;
    logic        ccrl;
    logic [7:0]  ccr;
    logic        axl;
    logic [7:0]  a;
    logic [7:0]  x;
    string       tag;
  } item_t;

  item_t exp_q[$];
  logic [15:0] sp_m = 16'h00FF;

  function automatic item_t mk(logic [15:0] addr, logic rd, logic [7:0] wd,
                               logic [15:0] sp, string tag);
    item_t it;
    it.addr = addr; it.rd = rd; it.wd = wd; it.sp = sp;
    it.pcl = 0; it.pc = '0; it.ccrl = 0; it.ccr = '0;
    it.axl = 0; it.a = '0; it.x = '0; it.tag = tag;
    return it;
  endfunction

  task automatic check(bit ok, string req, string what, string act, string exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%s expected=%s", req, what, act, exp);
    end
  endtask

  // monitor: compares every bus cycle against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_valid) begin
        if (exp_q.size() == 0) begin
          check(0, "R9", "unexpected access", $sformatf("%h", mem_addr), "none");
        end else begin
          item_t e;
          bit ok;
          e = exp_q.pop_front();
          ok = (mem_addr == e.addr) && (mem_read == e.rd) && (sp_out == e.sp) &&
               (e.rd || mem_wdata == e.wd) && busy &&
               (pc_load == e.pcl) && (!e.pcl || pc_new == e.pc) &&
               (ccr_load == e.ccrl) && (!e.ccrl || ccr_new == e.ccr) &&
               (ax_load == e.axl) && (!e.axl || (a_new == e.a && x_new == e.x));
          check(ok, e.tag, "bus cycle",
                $sformatf("addr=%h rd=%b wd=%h sp=%h pcl=%b pc=%h ccrl=%b ccr=%h axl=%b a=%h x=%h",
                          mem_addr, mem_read, mem_wdata, sp_out, pc_load, pc_new,
                          ccr_load, ccr_new, ax_load, a_new, x_new),
                $sformatf("addr=%h rd=%b wd=%h sp=%h pcl=%b pc=%h ccrl=%b ccr=%h axl=%b a=%h x=%h",
                          e.addr, e.rd, e.wd, e.sp, e.pcl, e.pc, e.ccrl, e.ccr,
                          e.axl, e.a, e.x));
        end
        if (!mem_read) mem[mem_addr] = mem_wdata;
      end else begin
        check(!busy && !pc_load && !ccr_load && !ax_load, "R8", "idle cycle",
              $sformatf("busy=%b pcl=%b ccrl=%b axl=%b", busy, pc_load, ccr_load, ax_load),
              "all 0");
      end
    end
  end

  task automatic wait_done(string req);
    wait (exp_q.size() == 0);
    @(posedge clk);
    @(negedge clk);
    check(!busy && !mem_valid, req, "sequence ended, no restart",
          $sformatf("busy=%b valid=%b", busy, mem_valid), "busy=0 valid=0");
  endtask

  // entry: R2 pushes, R3 vector and fetch, R4 mask set, R5 pointer
  task automatic do_entry(logic [15:0] pc, logic [7:0] a, logic [7:0] x,
                          logic [7:0] ccr, logic [15:0] vec, logic [7:0] vh,
                          logic [7:0] vl, bit inject, bit both);
    logic [15:0] rpc;
    item_t it;
    rpc = pc - 16'd1;
    mem[vec] = vh;
    mem[vec + 16'd1] = vl;
    exp_q.push_back(mk(sp_m,         0, rpc[7:0],  sp_m - 16'd1, "R2"));
    exp_q.push_back(mk(sp_m - 16'd1, 0, rpc[15:8], sp_m - 16'd2, "R2"));
    exp_q.push_back(mk(sp_m - 16'd2, 0, x,         sp_m - 16'd3, "R2"));
    exp_q.push_back(mk(sp_m - 16'd3, 0, a,         sp_m - 16'd4, "R2"));
    exp_q.push_back(mk(sp_m - 16'd4, 0, ccr,       sp_m - 16'd5, "R2"));
    it = mk(vec, 1, 8'h00, sp_m - 16'd5, "R3_R4");
    it.ccrl = 1; it.ccr = ccr | 8'h08;
    exp_q.push_back(it);
    exp_q.push_back(mk(vec + 16'd1, 1, 8'h00, sp_m - 16'd5, "R3"));
    it = mk({vh, vl}, 1, 8'h00, sp_m - 16'd5, "R3");
    it.pcl = 1; it.pc = {vh, vl};
    exp_q.push_back(it);
    sp_m = sp_m - 16'd5;
    @(negedge clk);
    pc_in = pc; a_in = a; x_in = x; ccr_in = ccr; vec_addr = vec;
    entry_req = 1'b1; rti_req = both;
    @(negedge clk);
    entry_req = 1'b0; rti_req = 1'b0;
    if (inject) begin
      // R9: requests and changed register inputs while busy
      @(negedge clk);
      entry_req = 1'b1; rti_req = 1'b1;
      pc_in = 16'hDEAD; x_in = 8'hEE; a_in = 8'hDD; ccr_in = 8'hFF;
      @(negedge clk);
      entry_req = 1'b0; rti_req = 1'b0;
    end
    wait_done(inject ? "R9" : (both ? "R10" : "R2"));
  endtask

  // return: R6 pulls and loads, R7 mask restore, R5 pointer
  task automatic do_rti(logic [15:0] pc, logic [7:0] a, logic [7:0] x,
                        logic [7:0] ccr, string tag);
    item_t it;
    for (int k = 0; k < 5; k++)
      exp_q.push_back(mk(sp_m + 16'(k + 1), 1, 8'h00, sp_m + 16'(k + 1), "R6"));
    it = mk(pc, 1, 8'h00, sp_m + 16'd5, tag);
    it.pcl = 1; it.pc = pc; it.ccrl = 1; it.ccr = ccr;
    it.axl = 1; it.a = a; it.x = x;
    exp_q.push_back(it);
    sp_m = sp_m + 16'd5;
    @(negedge clk);
    rti_req = 1'b1;
    @(negedge clk);
    rti_req = 1'b0;
    wait_done("R6");
  endtask

  int cycles = 0;
  bit done = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      failures++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !mem_valid && !pc_load && !ccr_load && !ax_load && sp_out == 16'h00FF,
          "R1", "state in reset",
          $sformatf("busy=%b valid=%b sp=%h", busy, mem_valid, sp_out),
          "busy=0 valid=0 sp=00ff");
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(!busy && !mem_valid && sp_out == 16'h00FF, "R1", "state after reset",
          $sformatf("busy=%b valid=%b sp=%h", busy, mem_valid, sp_out),
          "busy=0 valid=0 sp=00ff");

    // preloaded frame above SP: CCR, A, X, PCH, PCL; mask bit clear (R7)
    mem[16'h0100] = 8'h04;
    mem[16'h0101] = 8'h11;
    mem[16'h0102] = 8'h22;
    mem[16'h0103] = 8'h40;
    mem[16'h0104] = 8'h56;
    do_rti(16'h4056, 8'h11, 8'h22, 8'h04, "R6_R7");

    // entry with requests injected while busy (R9)
    do_entry(16'h1235, 8'hC3, 8'h5A, 8'h60, 16'hFFF4, 8'h80, 8'h10, 1, 0);
    // nested entry with both requests raised (R10)
    do_entry(16'h8020, 8'h01, 8'h02, 8'h68, 16'hFFF8, 8'h90, 8'h00, 0, 1);
    // unwind in LIFO order
    do_rti(16'h801F, 8'h01, 8'h02, 8'h68, "R6");
    do_rti(16'h1234, 8'hC3, 8'h5A, 8'h60, "R7");

    check(sp_out == 16'h0104, "R5", "pointer after two entries and two returns",
          $sformatf("%h", sp_out), "0104");
    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule